// File: doc/BRIEF.md
# Reload Timer with Baud Mode

This block is a 16-bit timer/counter with a 16-bit reload register. A control register sets how it runs. As an auto-reloading timer, it loads the reload value each time it wraps past 0xFFFF. In up/down mode, a level on the trigger pin sets the direction. In baud mode, its wraps become transmit and receive bit-rate ticks for a serial port.

The counter advances on one of two sources. The first is an internal prescaler, which gives one step every 12 clocks in normal mode and one step every 2 clocks in baud mode. The second is falling edges on the count pin. When trigger handling is enabled, a falling edge on the trigger pin raises a flag. Outside baud mode, that edge also forces an immediate reload. Both flags drive one interrupt request, and only a register write clears them.

Top module: `reload_timer16`

## Requirements
- R1: After reset: count_o is 0; ovf_flag_o, ext_flag_o, irq_o, dir_o, tx_tick_o and rx_tick_o are all 0.
- R2: The register write map is: address 0 control, address 1 flags, address 2 count low byte, address 3 count high byte, address 4 reload low byte, address 5 reload high byte. A count byte write takes effect at the write clock edge and overrides any count step or reload in that cycle.
- R3: The control register bits are: bit 0 run, bit 1 source select, bit 2 trigger enable, bit 3 up/down mode, bit 4 transmit clock, bit 5 receive clock. Baud mode is active when bit 4 or bit 5 is 1.
- R4: With run=1, source select=0 and baud mode off, the counter increments once every 12 clocks.
- R5: With run=1 and source select=1, the counter increments once per 1-to-0 change of the count pin after a two-stage synchronizer, and it ignores the internal prescaler.
- R6: In up counting, a step taken at 0xFFFF loads the reload value and sets the overflow flag (flag register bit 0).
- R7: In baud mode, the internal source steps once every 2 clocks. A wrap loads the reload value and pulses tx_tick_o for one cycle if bit 4 is set, and rx_tick_o if bit 5 is set. It never sets the overflow flag.
- R8: When trigger enable is set and up/down mode is off, a falling trigger edge sets the external flag (flag register bit 1). Outside baud mode, the same edge loads the reload value into the counter. In baud mode the count is left unchanged.
- R9: When trigger enable is 0, trigger edges set no flag and change no count.
- R10: In up/down mode, a trigger pin level of 1 counts up and 0 counts down. In down counting, a step taken when count equals reload loads 0xFFFF, sets the overflow flag and toggles dir_o. An up wrap in this mode also toggles dir_o.
- R11: A flag register write clears each flag whose data bit is 0. A 1 leaves the flag unchanged, so a write can never set a flag.
- R12: irq_o is 1 exactly when either flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | oscillator-rate clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| cnt_pin_i | input | 1 | external count pin |
| trig_pin_i | input | 1 | external trigger / direction pin |
| wr_en_i | input | 1 | register write strobe |
| wr_addr_i | input | 3 | register address |
| wr_data_i | input | 8 | register write data |
| count_o | output | 16 | current counter value |
| ovf_flag_o | output | 1 | overflow / underflow flag |
| ext_flag_o | output | 1 | trigger-edge flag |
| irq_o | output | 1 | interrupt request |
| dir_o | output | 1 | direction-tracking bit, toggled on each wrap in up/down mode |
| tx_tick_o | output | 1 | transmit baud tick |
| rx_tick_o | output | 1 | receive baud tick |

## Verification
The bench checks the exact cycle of each prescaled step, so a divider that is off by one shifts the count and is caught. It drives wraps at 0xFFFF and at count equal to reload. A design that wrapped one step early or late, loaded the wrong value, or set the overflow flag in baud mode would fail these checks. The bench also counts baud ticks over a fixed window, which catches a tick sent to the wrong direction or a wrong divide ratio. Flag writes with 1 bits, and trigger edges sent while the trigger is disabled or in baud mode, expose a flag that can be set by a write or a reload that happens when it should not.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd5;

  typedef struct packed {
    logic rx_clk;
    logic tx_clk;
    logic updown;
    logic ext_en;
    logic cnt_sel;
    logic run;
  } ctrl_t;
  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/rt_edge_sync.sv
module rt_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o
);
  logic s1, s2, prev;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1 <= 1'b1; s2 <= 1'b1; prev <= 1'b1;
    end else begin
      s1 <= pin_i; s2 <= s1; prev <= s2;
    end
  end
  assign level_o = s2;
  assign fall_o  = prev & ~s2;
endmodule

// File: rtl/rt_prescaler.sv
module rt_prescaler #(
  parameter int NORM_DIV = 12,
  parameter int BAUD_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic fast_i,
  output logic tick_o
);
  localparam int MAX_DIV = (NORM_DIV > BAUD_DIV) ? NORM_DIV : BAUD_DIV;
  localparam int PW = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;
  localparam logic [PW-1:0] NORM_LIM = PW'(NORM_DIV - 1);
  localparam logic [PW-1:0] BAUD_LIM = PW'(BAUD_DIV - 1);

  logic [PW-1:0] pre;
  logic [PW-1:0] lim;
  assign lim    = fast_i ? BAUD_LIM : NORM_LIM;
  assign tick_o = run_i & (pre >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre <= '0;
    else if (!run_i)  pre <= '0;
    else if (tick_o)  pre <= '0;
    else              pre <= pre + 1'b1;
  end
endmodule

// File: rtl/rt_count_core.sv
module rt_count_core #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         down_i,
  input  logic         updown_i,
  input  logic         force_i,
  input  logic         wr_lo_i,
  input  logic         wr_hi_i,
  input  logic [W/2-1:0] wr_byte_i,
  input  logic [W-1:0] rld_i,
  output logic [W-1:0] cnt_o,
  output logic         dir_o,
  output logic         wrap_o
);
  localparam int HB = W / 2;
  localparam logic [W-1:0] ONES = '1;

  logic at_end;
  assign at_end = down_i ? (cnt_o == rld_i) : (cnt_o == ONES);
  assign wrap_o = step_i & ~wr_lo_i & ~wr_hi_i & ~force_i & at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      dir_o <= 1'b0;
    end else if (wr_lo_i) begin
      cnt_o[HB-1:0] <= wr_byte_i;
    end else if (wr_hi_i) begin
      cnt_o[W-1:HB] <= wr_byte_i;
    end else if (force_i) begin
      cnt_o <= rld_i;
    end else if (step_i) begin
      if (at_end) begin
        cnt_o <= down_i ? ONES : rld_i;
        if (updown_i) dir_o <= ~dir_o;
      end else begin
        cnt_o <= down_i ? cnt_o - 1'b1 : cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/reload_timer16.sv
module reload_timer16 #(
  parameter int DATA_W   = 8,
  parameter int NORM_DIV = 12,
  parameter int BAUD_DIV = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cnt_pin_i,
  input  logic                  trig_pin_i,
  input  logic                  wr_en_i,
  input  logic [rt_pkg::ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  output logic [2*DATA_W-1:0]   count_o,
  output logic                  ovf_flag_o,
  output logic                  ext_flag_o,
  output logic                  irq_o,
  output logic                  dir_o,
  output logic                  tx_tick_o,
  output logic                  rx_tick_o
);
  import rt_pkg::*;
  localparam int CNT_W = 2 * DATA_W;

  ctrl_t            ctrl;
  logic [CNT_W-1:0] rld;
  logic baud_mode, updown_eff, down, ext_en;
  logic cnt_fall, cnt_lvl_unused, trig_fall, trig_lvl;
  logic pre_tick, step, ext_fire, force_rld, wrap;
  logic wr_ctrl, wr_flags, wr_cnt_lo, wr_cnt_hi;

  assign wr_ctrl   = wr_en_i && (wr_addr_i == A_CTRL);
  assign wr_flags  = wr_en_i && (wr_addr_i == A_FLAGS);
  assign wr_cnt_lo = wr_en_i && (wr_addr_i == A_CNT_LO);
  assign wr_cnt_hi = wr_en_i && (wr_addr_i == A_CNT_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl <= '0;
      rld  <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_CTRL)   ctrl <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
      if (wr_addr_i == A_RLD_LO) rld[DATA_W-1:0] <= wr_data_i;
      if (wr_addr_i == A_RLD_HI) rld[CNT_W-1:DATA_W] <= wr_data_i;
    end
  end

  assign baud_mode  = ctrl.tx_clk | ctrl.rx_clk;
  assign updown_eff = ctrl.updown & ~baud_mode;
  assign ext_en     = ctrl.ext_en;

  rt_edge_sync i_cnt_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(cnt_pin_i),
    .level_o(cnt_lvl_unused), .fall_o(cnt_fall)
  );
  rt_edge_sync i_trig_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(trig_pin_i),
    .level_o(trig_lvl), .fall_o(trig_fall)
  );

  rt_prescaler #(.NORM_DIV(NORM_DIV), .BAUD_DIV(BAUD_DIV)) i_pre (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .run_i(ctrl.run & ~ctrl.cnt_sel), .fast_i(baud_mode), .tick_o(pre_tick)
  );

  assign step      = ctrl.cnt_sel ? (ctrl.run & cnt_fall) : pre_tick;
  assign down      = updown_eff & ~trig_lvl;
  // in up/down mode the trigger pin is the direction input, not an event
  assign ext_fire  = ext_en & trig_fall & ~updown_eff;
  assign force_rld = ext_fire & ~baud_mode;

  rt_count_core #(.W(CNT_W)) i_core (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .step_i(step), .down_i(down), .updown_i(updown_eff),
    .force_i(force_rld), .wr_lo_i(wr_cnt_lo), .wr_hi_i(wr_cnt_hi),
    .wr_byte_i(wr_data_i), .rld_i(rld),
    .cnt_o(count_o), .dir_o(dir_o), .wrap_o(wrap)
  );

  logic ovf_set;
  assign ovf_set = wrap & ~baud_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_flag_o <= 1'b0;
      ext_flag_o <= 1'b0;
      tx_tick_o  <= 1'b0;
      rx_tick_o  <= 1'b0;
    end else begin
      // write can only clear; a set event in the same cycle wins
      ovf_flag_o <= (ovf_flag_o & ~(wr_flags & ~wr_data_i[0])) | ovf_set;
      ext_flag_o <= (ext_flag_o & ~(wr_flags & ~wr_data_i[1])) | ext_fire;
      tx_tick_o  <= wrap & baud_mode & ctrl.tx_clk;
      rx_tick_o  <= wrap & baud_mode & ctrl.rx_clk;
    end
  end

  assign irq_o = ovf_flag_o | ext_flag_o;

  logic unused_ok;
  assign unused_ok = ^{cnt_lvl_unused, wr_ctrl};
endmodule

// File: rtl/reload_timer16_chk.sv
module reload_timer16_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wr_en_i,
  input logic [W-1:0] count_o,
  input logic         ovf_flag_o,
  input logic         ext_flag_o,
  input logic         irq_o,
  input logic         tx_tick_o,
  input logic         rx_tick_o,
  input logic         baud,
  input logic         updown,
  input logic         ext_en,
  input logic         tx_en,
  input logic         rx_en,
  input logic [W-1:0] rld
);
  assert_baud_no_ovf_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_flag_o) |-> !$past(baud));

  assert_tx_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_tick_o |=> !tx_tick_o);

  assert_tick_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_tick_o |-> $past(tx_en)) and (rx_tick_o |-> $past(rx_en)));

  assert_ext_needs_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_flag_o) |-> $past(ext_en));

  assert_up_wrap_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ovf_flag_o) && !$past(updown) && !$past(wr_en_i)) |-> count_o == $past(rld));

  assert_irq_tracks_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_o || ext_flag_o) |-> irq_o);
endmodule

bind reload_timer16 reload_timer16_chk #(.W(2*DATA_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
  .count_o(count_o), .ovf_flag_o(ovf_flag_o), .ext_flag_o(ext_flag_o),
  .irq_o(irq_o), .tx_tick_o(tx_tick_o), .rx_tick_o(rx_tick_o),
  .baud(baud_mode), .updown(updown_eff), .ext_en(ext_en),
  .tx_en(ctrl.tx_clk), .rx_en(ctrl.rx_clk), .rld(rld)
);

// File: tb/test_reload_timer16.sv
module test_reload_timer16;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cnt_pin_i = 1'b1;
  logic        trig_pin_i = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [15:0] count_o;
  logic ovf_flag_o, ext_flag_o, irq_o, dir_o, tx_tick_o, rx_tick_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  reload_timer16 i_reload_timer16 (
    .clk_i, .rst_ni, .cnt_pin_i, .trig_pin_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .count_o, .ovf_flag_o, .ext_flag_o, .irq_o, .dir_o, .tx_tick_o, .rx_tick_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; cnt_pin_i = 1'b1; trig_pin_i = 1'b1;
    adv(2);
    rst_ni = 1'b1;
    adv(4);
  endtask

  task automatic set_cnt(input logic [15:0] v);
    wr(3'd2, v[7:0]); wr(3'd3, v[15:8]);
  endtask
  task automatic set_rld(input logic [15:0] v);
    wr(3'd4, v[7:0]); wr(3'd5, v[15:8]);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 count", count_o, 0);
    chk("R1 flags/irq", {ovf_flag_o, ext_flag_o, irq_o}, 0);
    chk("R1 dir/ticks", {dir_o, tx_tick_o, rx_tick_o}, 0);
  endtask

  task automatic t_internal();
    do_reset();
    set_cnt(16'h00FF);
    chk("R2 count write", count_o, 16'h00FF);
    wr(3'd0, 8'h01);
    adv(11);
    chk("R4 no step before 12", count_o, 16'h00FF);
    adv(1);
    chk("R4 step at 12", count_o, 16'h0100);
    adv(60);
    chk("R4 five more steps", count_o, 16'h0105);
  endtask

  task automatic t_pin();
    do_reset();
    set_cnt(16'h0010);
    wr(3'd0, 8'h03);
    adv(40);
    chk("R5 no internal steps", count_o, 16'h0010);
    for (int i = 0; i < 3; i++) begin
      cnt_pin_i = 1'b0; adv(2);
      cnt_pin_i = 1'b1; adv(2);
    end
    adv(4);
    chk("R5 three pin edges", count_o, 16'h0013);
  endtask

  task automatic t_overflow();
    do_reset();
    set_rld(16'h1234);
    set_cnt(16'hFFFE);
    wr(3'd0, 8'h01);
    adv(23);
    chk("R6 at FFFF", count_o, 16'hFFFF);
    chk("R6 flag still 0", ovf_flag_o, 0);
    adv(1);
    chk("R6 reloaded", count_o, 16'h1234);
    chk("R6 ovf flag", ovf_flag_o, 1);
    chk("R12 irq", irq_o, 1);
  endtask

  task automatic t_flags();
    t_overflow();
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h03);
    chk("R11 ovf kept by 1", ovf_flag_o, 1);
    chk("R11 ext not set by 1", ext_flag_o, 0);
    wr(3'd1, 8'h02);
    chk("R11 ovf cleared by 0", ovf_flag_o, 0);
    chk("R12 irq low", irq_o, 0);
  endtask

  task automatic t_baud();
    int ticks;
    do_reset();
    set_rld(16'hFFF0);
    set_cnt(16'hFFFE);
    wr(3'd0, 8'h11);
    adv(2);
    chk("R7 step every 2", count_o, 16'hFFFF);
    adv(2);
    chk("R7 reload", count_o, 16'hFFF0);
    chk("R7 tx tick", {tx_tick_o, rx_tick_o}, 2'b10);
    chk("R7 no ovf flag", ovf_flag_o, 0);
    ticks = 0;
    for (int i = 0; i < 160; i++) begin
      adv(1);
      if (tx_tick_o) ticks++;
    end
    chk("R7 tick rate", ticks, 5);
    do_reset();
    set_rld(16'hFFFE);
    set_cnt(16'hFFFF);
    wr(3'd0, 8'h21);
    adv(2);
    chk("R7 rx tick only", {tx_tick_o, rx_tick_o}, 2'b01);
    chk("R7 rx reload", count_o, 16'hFFFE);
  endtask

  task automatic t_ext();
    do_reset();
    set_rld(16'hABCD);
    set_cnt(16'h0005);
    wr(3'd0, 8'h00);
    trig_pin_i = 1'b0; adv(4); trig_pin_i = 1'b1; adv(4);
    chk("R9 no reload", count_o, 16'h0005);
    chk("R9 no flag", ext_flag_o, 0);
    wr(3'd0, 8'h04);
    trig_pin_i = 1'b0; adv(4); trig_pin_i = 1'b1; adv(4);
    chk("R8 forced reload", count_o, 16'hABCD);
    chk("R8 ext flag", {ext_flag_o, irq_o}, 2'b11);
    wr(3'd1, 8'h01);
    chk("R11 ext cleared", ext_flag_o, 0);
    set_cnt(16'h0007);
    wr(3'd0, 8'h14);
    trig_pin_i = 1'b0; adv(4); trig_pin_i = 1'b1; adv(4);
    chk("R8 baud keeps count", count_o, 16'h0007);
    chk("R8 baud flag", ext_flag_o, 1);
  endtask

  task automatic t_updown();
    do_reset();
    trig_pin_i = 1'b0; adv(4);
    set_rld(16'h0100);
    set_cnt(16'h0102);
    wr(3'd0, 8'h09);
    adv(24);
    chk("R10 down to reload", count_o, 16'h0100);
    chk("R10 no flag yet", ovf_flag_o, 0);
    adv(12);
    chk("R10 underflow load", count_o, 16'hFFFF);
    chk("R10 ovf flag", ovf_flag_o, 1);
    chk("R10 dir toggled", dir_o, 1);
    trig_pin_i = 1'b1; adv(4);
    wr(3'd0, 8'h08);
    set_cnt(16'hFFFF);
    wr(3'd0, 8'h09);
    adv(12);
    chk("R10 up wrap reload", count_o, 16'h0100);
    chk("R10 dir toggled back", dir_o, 0);
  endtask

  initial begin
    t_reset();
    t_internal();
    t_pin();
    t_overflow();
    t_flags();
    t_baud();
    t_ext();
    t_updown();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule